// File: doc/BRIEF.md
# UART Transmit Framer

This block turns characters into asynchronous serial frames on a single transmit line. A character arrives on a valid/ready stream input. When the framer accepts it, the framer takes a copy of the current line-control word, builds the whole frame and shifts it out. Each bit time is measured by counting pulses of an external tick that runs at sixteen times the baud rate.

The line-control word sets the frame format. It chooses a data length of five to eight bits, one or two stop bits, whether a parity bit is sent, and the parity rule. A separate control bit forces the line low to send a break. The transmit line idles high. An idle output tells status logic that no frame is in flight.

Back-pressure rules for the stream input:
- `in_ready` is high only while no frame is in progress.
- A character is taken on a rising clock edge where both `in_valid` and `in_ready` are high.
- From the next cycle `in_ready` stays low until the last stop bit has finished.
- A producer may hold `in_valid` and `in_data` steady while `in_ready` is low. The held character is taken on the first edge after the frame completes.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset, `txd` is 1, and `idle` and `in_ready` are both 1.
- R2: A character is accepted on an edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle until the frame ends. While `in_ready` is 0, a held `in_valid` has no effect on the frame being sent.
- R3: A frame is sent in this order: a 0 start bit, the data bits least significant first, the optional parity bit, then the stop bits at 1. The start bit appears on `txd` in the cycle after the accepting edge.
- R4: `lcr[1:0]` is the number of data bits minus 5. Data bits above the selected length are not sent and do not affect parity.
- R5: `lcr[2]` = 0 sends one stop bit and `lcr[2]` = 1 sends two.
- R6: `lcr[3]` = 1 inserts a parity bit after the data bits, and `lcr[5:4]` picks its value. With 0, the data bits plus the parity bit hold an odd number of ones. With 1, they hold an even number. With 2, the bit is 1. With 3, the bit is 0.
- R7: While `lcr[6]` is 1, `txd` is 0, starting one cycle after the bit is set. `txd` is released one cycle after the bit clears. A frame in flight keeps its timing under a break.
- R8: The format is captured on the accepting edge. Changes to `lcr[5:0]` during a frame do not alter that frame.
- R9: `idle` is 0 while a frame is in flight and returns to 1 on the edge that ends the last stop bit. While idle and not in break, `txd` is 1.
- R10: Every bit lasts exactly 16 cycles in which `tick16` is high. While `tick16` stays low, the frame and `txd` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle pulse at sixteen times the baud rate |
| lcr | input | 7 | Line control: [1:0] length code, [2] stop count, [3] parity enable, [5:4] parity rule, [6] break |
| in_valid | input | 1 | Stream input: character offered |
| in_ready | output | 1 | Stream input: framer can take a character |
| in_data | input | 8 | Stream input: character, bit 0 sent first |
| txd | output | 1 | Serial transmit line, idles high |
| idle | output | 1 | High when no frame is in flight |

## Verification
The start bit drives `txd` one cycle after the accepting edge. Bit k of the frame then spans 16 ticks from 16·k ticks later. `idle` and `in_ready` go high one cycle after the edge that ends the last stop bit, and break acts on `txd` one cycle after `lcr[6]` changes. The bench drives inputs on falling edges and counts falling edges from the accepting edge. It samples each bit at its midpoint, 8 tick periods into the bit, so a tick phase offset of up to one tick period cannot move a sample across a bit boundary. It samples `idle` one tick period before and exactly at the computed frame end, the two points that bracket the end for any tick phase.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;

  typedef enum logic [1:0] {
    PAR_ODD  = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ONE  = 2'd2,
    PAR_ZERO = 2'd3
  } par_mode_e;

  // Packed so that the field order matches the line-control bit positions.
  typedef struct packed {
    logic      brk;
    par_mode_e par_mode;
    logic      par_en;
    logic      two_stop;
    logic [1:0] wlen_code;
  } line_ctl_t;

endpackage

// File: rtl/txf_frame_build.sv
module txf_frame_build
  import uart_txf_pkg::*;
#(
  parameter int DATA_MAX = 8,
  parameter int MIN_WLEN = 5,
  parameter int FRAME_W  = 12,
  parameter int LEN_W    = 4
) (
  input  logic [1:0]          wlen_code_i,
  input  logic                two_stop_i,
  input  logic                par_en_i,
  input  par_mode_e           par_mode_i,
  input  logic [DATA_MAX-1:0] data_i,
  output logic [FRAME_W-1:0]  frame_o,
  output logic [LEN_W-1:0]    len_o
);

  logic [LEN_W-1:0]    nbits;
  logic [DATA_MAX-1:0] keep;
  logic                ones_xor;
  logic                par_bit;

  assign nbits = LEN_W'(MIN_WLEN) + LEN_W'(wlen_code_i);

  for (genvar i = 0; i < DATA_MAX; i++) begin : g_keep
    assign keep[i] = (LEN_W'(i) < nbits);
  end

  assign ones_xor = ^(data_i & keep);

  always_comb begin
    unique case (par_mode_i)
      PAR_ODD:  par_bit = ~ones_xor;
      PAR_EVEN: par_bit = ones_xor;
      PAR_ONE:  par_bit = 1'b1;
      default:  par_bit = 1'b0;
    endcase
  end

  // Unused upper positions stay 1, so they serve as stop bits.
  always_comb begin
    frame_o    = '1;
    frame_o[0] = 1'b0;
    for (int i = 0; i < DATA_MAX; i++) begin
      if (keep[i]) frame_o[1+i] = data_i[i];
    end
    if (par_en_i) frame_o[int'(nbits) + 1] = par_bit;
  end

  assign len_o = LEN_W'(2) + nbits + LEN_W'(par_en_i) + LEN_W'(two_stop_i);

endmodule

// File: rtl/txf_bit_timer.sv
module txf_bit_timer #(
  parameter int OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic tick_i,
  output logic bit_end_o
);

  localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign bit_end_o = tick_i && (cnt_q == LAST) && !clear_i;

  // R10: without a tick the bit phase does not move
  a_r10_no_tick_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clear_i) |=> $stable(cnt_q));

endmodule

// File: rtl/txf_shift_engine.sv
module txf_shift_engine #(
  parameter int FRAME_W = 12,
  parameter int LEN_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               bit_end_i,
  output logic               busy_o,
  output logic               line_o
);

  logic [FRAME_W-1:0] frame_q;
  logic [LEN_W-1:0]   left_q;
  logic               busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
      left_q  <= '0;
      busy_q  <= 1'b0;
    end else if (load_i) begin
      frame_q <= frame_i;
      left_q  <= len_i;
      busy_q  <= 1'b1;
    end else if (busy_q && bit_end_i) begin
      frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
      left_q  <= left_q - 1'b1;
      if (left_q == LEN_W'(1)) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign line_o = busy_q ? frame_q[0] : 1'b1;

  // R3: a freshly loaded frame opens with a low start bit
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !line_o);

  // R8: between bit boundaries the captured frame is frozen
  a_r8_frame_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !bit_end_i && !load_i) |=> ($stable(frame_q) && $stable(left_q)));

  // R5/R9: the final bit of every frame is a high stop bit
  a_r9_last_is_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && bit_end_i && left_q == LEN_W'(1)) |-> line_o);

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_txf_pkg::*;
#(
  parameter int DATA_MAX   = 8,
  parameter int MIN_WLEN   = 5,
  parameter int OVERSAMPLE = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick16,
  input  logic [6:0]          lcr,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_MAX-1:0] in_data,
  output logic                txd,
  output logic                idle
);

  localparam int FRAME_W = 1 + DATA_MAX + 1 + 2;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  line_ctl_t          ctl;
  logic               accept;
  logic               busy;
  logic               line;
  logic               bit_end;
  logic               brk_q;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   len;

  assign ctl      = line_ctl_t'(lcr);
  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  txf_frame_build #(
    .DATA_MAX(DATA_MAX), .MIN_WLEN(MIN_WLEN), .FRAME_W(FRAME_W), .LEN_W(LEN_W)
  ) u_build (
    .wlen_code_i(ctl.wlen_code),
    .two_stop_i (ctl.two_stop),
    .par_en_i   (ctl.par_en),
    .par_mode_i (ctl.par_mode),
    .data_i     (in_data),
    .frame_o    (frame),
    .len_o      (len)
  );

  txf_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (accept),
    .tick_i   (tick16),
    .bit_end_o(bit_end)
  );

  txf_shift_engine #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (accept),
    .frame_i  (frame),
    .len_i    (len),
    .bit_end_i(bit_end),
    .busy_o   (busy),
    .line_o   (line)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk_q <= 1'b0;
    else        brk_q <= ctl.brk;
  end

  assign txd  = line && !brk_q;
  assign idle = !busy;

  // R2: the stream closes for the duration of an accepted frame
  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R7: a requested break pulls the line low on the following cycle
  a_r7_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    lcr[6] |=> !txd);

  // R9: an idle line without break rests high
  a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !$past(lcr[6])) |-> txd);

endmodule

// File: tb/uart_tx_framer_test.sv
`timescale 1ns/1ps
module uart_tx_framer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic [6:0] lcr = 7'b0000011;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, txd, idle;

  int n_checks = 0;
  int n_err    = 0;
  int t        = 0;
  int tick_div = 1;
  int tcnt     = 0;

  always #2.5 clk = ~clk;

  uart_tx_framer uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .lcr(lcr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .txd(txd), .idle(idle)
  );

  always @(negedge clk) begin
    if (tick_div == 0) begin
      tick16 <= 1'b0;
    end else begin
      tick16 <= (tcnt == 0);
      tcnt   <= (tcnt + 1 >= tick_div) ? 0 : tcnt + 1;
    end
  end

  // vector: {lcr[5:0], data[7:0], tick period[3:0]}
  localparam int NV = 8;
  localparam logic [17:0] VEC [NV] = '{
    {6'b000011, 8'hA5, 4'd1},
    {6'b000000, 8'hFF, 4'd1},
    {6'b001001, 8'h2B, 4'd1},
    {6'b011010, 8'h81, 4'd2},
    {6'b101111, 8'h00, 4'd1},
    {6'b111101, 8'h3F, 4'd3},
    {6'b000110, 8'h55, 4'd1},
    {6'b001011, 8'h00, 4'd1}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0d)", req, act, exp, t);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
  endtask

  function automatic logic [11:0] ref_frame(input logic [5:0] l, input logic [7:0] d, output int len);
    int n;
    int ones;
    logic [11:0] f;
    n = 5 + int'(l[1:0]);
    ones = 0;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < n; i++) begin
      f[1+i] = d[i];
      ones += int'(d[i]);
    end
    if (l[3]) begin
      case (l[5:4])
        2'd0: f[n+1] = ((ones % 2) == 0);
        2'd1: f[n+1] = ((ones % 2) == 1);
        2'd2: f[n+1] = 1'b1;
        default: f[n+1] = 1'b0;
      endcase
    end
    len = 1 + n + int'(l[3]) + 1 + int'(l[2]);
    return f;
  endfunction

  task automatic wait_to(input int target);
    while (t < target) begin
      @(negedge clk);
      t++;
    end
  endtask

  // Offers a character; returns at the falling edge after the accepting edge (t = 0).
  task automatic send(input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    t = 0;
  endtask

  function automatic string tag_of(input int k, input int n, input bit pe);
    if (k == 0) return "R3 start";
    if (k <= n) return "R4 data";
    if (pe && k == n + 1) return "R6 parity";
    return "R5 stop";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [11:0] f;
    int len;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(txd == 1'b1, "R1 txd", txd, 1);
    check(idle == 1'b1, "R1 idle", idle, 1);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(txd == 1'b1, "R1 txd after release", txd, 1);

    // table of formats and characters
    for (int v = 0; v < NV; v++) begin
      logic [5:0] l;
      logic [7:0] d;
      int dv;
      l  = VEC[v][17:12];
      d  = VEC[v][11:4];
      dv = int'(VEC[v][3:0]);
      lcr = {1'b0, l};
      tick_div = dv;
      f = ref_frame(l, d, len);
      send(d);
      check(in_ready == 1'b0, "R2 ready low in frame", in_ready, 0);
      for (int k = 0; k < len; k++) begin
        wait_to(8*dv + 16*dv*k);
        check(txd == f[k], tag_of(k, 5 + int'(l[1:0]), l[3]), txd, f[k]);
      end
      wait_to(16*dv*len - dv);
      check(idle == 1'b0, "R9 busy before end", idle, 0);
      wait_to(16*dv*len);
      check(idle == 1'b1, "R9 idle at end", idle, 1);
      check(in_ready == 1'b1, "R2 ready at end", in_ready, 1);
      check(txd == 1'b1, "R9 line high idle", txd, 1);
    end

    // R8 format frozen, R2 held valid waits
    tick_div = 1;
    lcr = 7'b0000011;
    f = ref_frame(6'b000011, 8'h0F, len);
    send(8'h0F);
    wait_to(20);
    lcr = 7'b0111100;
    in_valid = 1'b1;
    in_data = 8'h00;
    for (int k = 1; k < len; k++) begin
      wait_to(8 + 16*k);
      check(txd == f[k], "R8 frame unchanged", txd, f[k]);
      if (k == 3) check(in_ready == 1'b0, "R2 held valid ignored", in_ready, 0);
    end
    wait_to(16*len);
    check(idle == 1'b1, "R8 end time unchanged", idle, 1);
    @(negedge clk);
    t++;
    in_valid = 1'b0;
    check(idle == 1'b0, "R2 held char taken", idle, 0);
    check(txd == 1'b0, "R2 held char start", txd, 0);
    wait_to(16*len + 1 + 16*12 + 4);
    check(idle == 1'b1, "R2 second frame done", idle, 1);

    // R7 break while idle
    lcr = 7'b1000011;
    @(negedge clk);
    check(txd == 1'b0, "R7 break idle low", txd, 0);
    repeat (5) @(negedge clk);
    check(txd == 1'b0, "R7 break held", txd, 0);
    check(idle == 1'b1, "R7 idle under break", idle, 1);
    lcr = 7'b0000011;
    @(negedge clk);
    check(txd == 1'b1, "R7 break released", txd, 1);

    // R7 break during a frame keeps timing
    send(8'hFF);
    wait_to(66);
    lcr = 7'b1000011;
    wait_to(67);
    check(txd == 1'b0, "R7 break mid frame", txd, 0);
    wait_to(70);
    lcr = 7'b0000011;
    wait_to(71);
    check(txd == 1'b1, "R7 release mid frame", txd, 1);
    wait_to(159);
    check(idle == 1'b0, "R7 frame timing busy", idle, 0);
    wait_to(160);
    check(idle == 1'b1, "R7 frame timing end", idle, 1);

    // R10 ticks stopped mid-bit
    f = ref_frame(6'b000011, 8'h0F, len);
    send(8'h0F);
    wait_to(40);
    tick_div = 0;
    wait_to(140);
    check(txd == 1'b1, "R10 hold line", txd, 1);
    check(idle == 1'b0, "R10 hold busy", idle, 0);
    tick_div = 1;
    tcnt = 0;
    wait_to(147);
    check(txd == f[2], "R10 bit stretched", txd, f[2]);
    wait_to(160);
    check(txd == f[3], "R10 next bit", txd, f[3]);
    wait_to(188);
    check(txd == f[5], "R10 later bit", txd, f[5]);
    wait_to(300);
    check(idle == 1'b1, "R10 frame completes", idle, 1);

    summary();
    $finish;
  end

endmodule